// File: doc/BRIEF.md
# Address-Line-20 Gate and Fast Warm-Reset Emulator

This block watches host I/O writes and takes over two jobs that a keyboard controller normally does slowly. The first is the address line 20 mask. A command byte arms the block, and the following data byte selects whether the CPU's line 20 reaches memory or is held low. When it is held low, addresses wrap at 1 MB. The second is the CPU warm reset: one command byte pattern starts a fixed-length reset pulse. The pulse can be preceded by a halt handshake, so the CPU is stopped before it is reset.

A separate system control port gives a second path to both functions. On that port, one bit sets the gate and another bit requests the reset. The current gate state can be read back on that port. A two-bit selector decides which of the two paths is active: the emulated keyboard-controller ports, the control port, or both.

Top module: `a20_reset_emu`

## Requirements
- R1: After synchronous reset, a20_out, cpu_reset and halt_req are 0, and p92_rdata bit 1 is 0, so the gate starts closed.
- R2: On the keyboard path, a write of D1h to port 64h followed by a write to port 60h sets the gate. Data 02h opens the gate and data 00h closes it.
- R3: a20_out equals cpu_a20 AND the gate state, registered one clock later.
- R4: A write to port 60h while the block is not armed leaves the gate unchanged. A port 60h write with data other than 00h or 02h uses up the arm and also leaves the gate unchanged.
- R5: While the block is armed, any port 64h write other than D1h cancels the arm, so a later port 60h write has no effect.
- R6: A port 64h write whose data matches 1111xxx0b (for example FEh or F0h) requests a warm reset. FFh does not request one.
- R7: A write to port 92h copies data bit 1 into the gate, and data bit 0 set to 1 requests a warm reset. p92_rdata shows the gate state in bit 1, and all other bits read 0.
- R8: mode 00 enables only ports 60h/64h, mode 01 enables only port 92h, and modes 10 and 11 enable both. Writes to a disabled path change nothing.
- R9: A warm reset drives cpu_reset high for exactly 16 clocks. Requests that arrive while a reset sequence is already running are ignored.
- R10: With halt_before_rst high, a request raises halt_req first. halt_req stays high until halt_ack is sampled high, and cpu_reset rises on that same clock edge.
- R11: If no halt_ack arrives, halt_req lasts exactly 256 clocks and the reset pulse follows anyway.
- R12: halt_req and cpu_reset are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mode | input | 2 | Path select: 00 keyboard ports, 01 control port, 1x both |
| halt_before_rst | input | 1 | Request a CPU halt before the reset pulse |
| cpu_a20 | input | 1 | CPU address line 20 |
| halt_ack | input | 1 | CPU halt acknowledge |
| a20_out | output | 1 | Gated address line 20 |
| p92_rdata | output | 8 | Read value of the control port |
| halt_req | output | 1 | Halt request to the CPU |
| cpu_reset | output | 1 | CPU warm-reset pulse |

## Verification
A single write to port 92h can change the gate and start a reset in the same clock, so the gate update and the reset sequencer act on one edge. The bench provokes this with data 03h in mode 01. It then checks that the readback shows the gate open on the next sample. The scoreboard must also receive exactly one 16-clock pulse. A second collision is tested by writing a reset command while a pulse is already running. The scoreboard must see only the first pulse, and an unexpected pulse counts as a failure.

// File: rtl/a20e_pkg.sv
package a20e_pkg;
  localparam logic [15:0] PORT_KDATA = 16'h0060;
  localparam logic [15:0] PORT_KCMD  = 16'h0064;
  localparam logic [15:0] PORT_SYSC  = 16'h0092;
  localparam logic [7:0]  CMD_ARM    = 8'hD1;
  localparam logic [7:0]  VAL_OPEN   = 8'h02;
  localparam logic [7:0]  VAL_CLOSE  = 8'h00;
  localparam logic [1:0]  MODE_KBC   = 2'b00;
  localparam logic [1:0]  MODE_SYSC  = 2'b01;
  typedef enum logic [1:0] {SQ_IDLE, SQ_HALT, SQ_PULSE} seq_state_t;
endpackage

// File: rtl/a20e_decode.sv
module a20e_decode
  import a20e_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic [1:0]  mode,
  output logic        gate_wr,
  output logic        gate_val,
  output logic        rst_req
);
  logic armed;
  logic kbc_on, sysc_on;
  logic hit_cmd, hit_data, hit_sysc;

  assign kbc_on   = (mode != MODE_SYSC);
  assign sysc_on  = (mode != MODE_KBC);
  assign hit_cmd  = io_wr && kbc_on && (io_addr == PORT_KCMD);
  assign hit_data = io_wr && kbc_on && (io_addr == PORT_KDATA);
  assign hit_sysc = io_wr && sysc_on && (io_addr == PORT_SYSC);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (hit_cmd) begin
      armed <= (io_wdata == CMD_ARM);
    end else if (hit_data) begin
      armed <= 1'b0;
    end
  end

  always_comb begin
    gate_wr  = 1'b0;
    gate_val = 1'b0;
    rst_req  = 1'b0;
    if (hit_data && armed) begin
      if (io_wdata == VAL_OPEN) begin
        gate_wr  = 1'b1;
        gate_val = 1'b1;
      end else if (io_wdata == VAL_CLOSE) begin
        gate_wr  = 1'b1;
        gate_val = 1'b0;
      end
    end
    if (hit_sysc) begin
      gate_wr  = 1'b1;
      gate_val = io_wdata[1];
      rst_req  = io_wdata[0];
    end
    if (hit_cmd && (io_wdata[7:4] == 4'hF) && !io_wdata[0]) begin
      rst_req = 1'b1;
    end
  end
endmodule

// File: rtl/a20e_gate.sv
module a20e_gate (
  input  logic clk,
  input  logic rst,
  input  logic gate_wr,
  input  logic gate_val,
  input  logic cpu_a20,
  output logic gate_en,
  output logic a20_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en <= 1'b0;
      a20_out <= 1'b0;
    end else begin
      if (gate_wr) gate_en <= gate_val;
      a20_out <= cpu_a20 & gate_en;
    end
  end
endmodule

// File: rtl/a20e_rstseq.sv
module a20e_rstseq
  import a20e_pkg::*;
#(
  parameter int RST_LEN = 16,
  parameter int HALT_TO = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic halt_en,
  input  logic halt_ack,
  output logic halt_req,
  output logic cpu_reset
);
  localparam int MAXC = (RST_LEN > HALT_TO) ? RST_LEN : HALT_TO;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(RST_LEN - 1);
  localparam logic [CW-1:0] HALT_LAST  = CW'(HALT_TO - 1);

  seq_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      cnt       <= '0;
      halt_req  <= 1'b0;
      cpu_reset <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          cnt <= '0;
          if (req) begin
            if (halt_en) begin
              st       <= SQ_HALT;
              halt_req <= 1'b1;
            end else begin
              st        <= SQ_PULSE;
              cpu_reset <= 1'b1;
            end
          end
        end
        SQ_HALT: begin
          if (halt_ack || cnt == HALT_LAST) begin
            st        <= SQ_PULSE;
            halt_req  <= 1'b0;
            cpu_reset <= 1'b1;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_PULSE: begin
          if (cnt == PULSE_LAST) begin
            st        <= SQ_IDLE;
            cpu_reset <= 1'b0;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a20_reset_emu.sv
module a20_reset_emu #(
  parameter int RST_LEN = 16,
  parameter int HALT_TO = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic [1:0]  mode,
  input  logic        halt_before_rst,
  input  logic        cpu_a20,
  input  logic        halt_ack,
  output logic        a20_out,
  output logic [7:0]  p92_rdata,
  output logic        halt_req,
  output logic        cpu_reset
);
  logic gate_wr, gate_val, rst_req, gate_en;

  a20e_decode u_dec (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mode(mode),
    .gate_wr(gate_wr), .gate_val(gate_val), .rst_req(rst_req)
  );

  a20e_gate u_gate (
    .clk(clk), .rst(rst), .gate_wr(gate_wr), .gate_val(gate_val),
    .cpu_a20(cpu_a20), .gate_en(gate_en), .a20_out(a20_out)
  );

  a20e_rstseq #(.RST_LEN(RST_LEN), .HALT_TO(HALT_TO)) u_seq (
    .clk(clk), .rst(rst), .req(rst_req), .halt_en(halt_before_rst),
    .halt_ack(halt_ack), .halt_req(halt_req), .cpu_reset(cpu_reset)
  );

  assign p92_rdata = {6'b0, gate_en, 1'b0};
endmodule

// File: rtl/a20_reset_emu_chk.sv
module a20_reset_emu_chk #(
  parameter int RST_LEN = 16,
  parameter int HALT_TO = 256
) (
  input logic        clk,
  input logic        rst,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [1:0]  mode,
  input logic        cpu_a20,
  input logic        a20_out,
  input logic [7:0]  p92_rdata,
  input logic        halt_req,
  input logic        cpu_reset
);
  int unsigned prun, hrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      prun <= 0;
      hrun <= 0;
    end else begin
      prun <= cpu_reset ? prun + 1 : 0;
      hrun <= halt_req ? hrun + 1 : 0;
    end
  end

  // R12
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(halt_req && cpu_reset));

  // R10
  halt_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(halt_req) |-> cpu_reset);

  // R3
  gate_and_chk: assert property (@(posedge clk) disable iff (rst)
    a20_out |-> $past(cpu_a20));

  // R8
  sysc_only_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && mode == 2'b01 && io_addr != 16'h0092) |=> $stable(p92_rdata));

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_reset |-> (prun < RST_LEN));

  // R11
  halt_len_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> (hrun < HALT_TO));
endmodule

bind a20_reset_emu a20_reset_emu_chk #(.RST_LEN(RST_LEN), .HALT_TO(HALT_TO)) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .mode(mode),
  .cpu_a20(cpu_a20), .a20_out(a20_out), .p92_rdata(p92_rdata),
  .halt_req(halt_req), .cpu_reset(cpu_reset)
);

// File: tb/tb_a20_reset_emu.sv
module tb_a20_reset_emu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [1:0]  mode = 2'b00;
  logic        halt_before_rst = 1'b0;
  logic        cpu_a20 = 1'b1;
  logic        halt_ack = 1'b0;
  logic        a20_out;
  logic [7:0]  p92_rdata;
  logic        halt_req;
  logic        cpu_reset;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int    exp_h[$];
  int    exp_p[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  a20_reset_emu dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .mode(mode), .halt_before_rst(halt_before_rst), .cpu_a20(cpu_a20),
    .halt_ack(halt_ack), .a20_out(a20_out), .p92_rdata(p92_rdata),
    .halt_req(halt_req), .cpu_reset(cpu_reset)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic push_rst(int hlen, string tag);
    exp_h.push_back(hlen);
    exp_p.push_back(16);
    exp_tag.push_back(tag);
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  int hcnt = 0;
  int pcnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (halt_req) hcnt++;
      if (cpu_reset) pcnt++;
      else if (pcnt > 0) begin
        if (exp_p.size() == 0) begin
          chk("R9 unexpected reset pulse", pcnt, 0);
        end else begin
          automatic string t = exp_tag.pop_front();
          chk({t, " halt length"}, hcnt, exp_h.pop_front());
          chk({t, " pulse length"}, pcnt, exp_p.pop_front());
        end
        hcnt = 0;
        pcnt = 0;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 a20_out", a20_out, 0);
    chk("R1 cpu_reset", cpu_reset, 0);
    chk("R1 halt_req", halt_req, 0);
    chk("R1 p92 bit1", p92_rdata[1], 0);

    // R2 arm then open, mode 00
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'h02);
    @(negedge clk);
    chk("R2 open", a20_out, 1);
    // R3 gating follows cpu_a20 one clock later
    cpu_a20 = 1'b0;
    @(negedge clk);
    chk("R3 cpu_a20 low", a20_out, 0);
    cpu_a20 = 1'b1;
    @(negedge clk);
    chk("R3 cpu_a20 high", a20_out, 1);
    // R2 close
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'h00);
    @(negedge clk);
    chk("R2 close", a20_out, 0);
    chk("R3 closed with cpu_a20 high", a20_out & cpu_a20, 0);

    // R4 unarmed data write ignored
    wr(16'h0060, 8'h02);
    @(negedge clk);
    chk("R4 unarmed write", a20_out, 0);
    // R4 odd data consumes arm
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'h55);
    wr(16'h0060, 8'h02);
    @(negedge clk);
    chk("R4 arm consumed", a20_out, 0);

    // R5 cancel by another command
    wr(16'h0064, 8'hD1);
    wr(16'h0064, 8'hAD);
    wr(16'h0060, 8'h02);
    @(negedge clk);
    chk("R5 cancelled", a20_out, 0);

    // R6 FFh does not reset; FEh does; F0h does
    wr(16'h0064, 8'hFF);
    repeat (30) @(negedge clk);
    chk("R6 FFh no pulse", exp_p.size(), 0);
    push_rst(0, "R6 FEh");
    wr(16'h0064, 8'hFE);
    // R9 second request during pulse ignored
    repeat (4) @(negedge clk);
    wr(16'h0064, 8'hFE);
    settle();
    push_rst(0, "R6 F0h");
    wr(16'h0064, 8'hF0);
    settle();

    // R8 mode 01: keyboard path disabled
    mode = 2'b01;
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'h02);
    wr(16'h0064, 8'hFE);
    @(negedge clk);
    chk("R8 mode01 kbc ignored", p92_rdata[1], 0);
    settle();
    // R7 port 92 open + reset in one write (same-cycle collision)
    push_rst(0, "R7 port92 bit0");
    wr(16'h0092, 8'h03);
    chk("R7 readback", p92_rdata, 8'h02);
    @(negedge clk);
    chk("R7 a20 open", a20_out, 1);
    settle();

    // R8 mode 00: port 92 disabled
    mode = 2'b00;
    wr(16'h0092, 8'h00);
    @(negedge clk);
    chk("R8 mode00 p92 ignored", a20_out, 1);
    // R8 mode 10: both paths
    mode = 2'b10;
    wr(16'h0092, 8'h00);
    @(negedge clk);
    chk("R8 mode10 p92 close", a20_out, 0);
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'h02);
    @(negedge clk);
    chk("R8 mode10 kbc open", a20_out, 1);

    // R10 halt then ack
    halt_before_rst = 1'b1;
    push_rst(6, "R10 halt ack");
    wr(16'h0064, 8'hFE);
    repeat (5) @(negedge clk);
    halt_ack = 1'b1;
    @(negedge clk);
    halt_ack = 1'b0;
    settle();

    // R11 halt timeout
    push_rst(256, "R11 halt timeout");
    wr(16'h0064, 8'hFE);
    repeat (600) @(negedge clk);
    halt_before_rst = 1'b0;

    chk("R9 scoreboard drained", exp_p.size(), 0);
    chk("R12 outputs idle", halt_req + cpu_reset, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule